// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block moves a processor's run-time context to and from a stack in memory, so that taking an interrupt leaves the interrupted program undisturbed apart from the time it loses. When the core accepts an interrupt, it pulses `irq_take` and presents the resume address (the instruction that would have run next) together with its condition flags. The sequencer latches both values. It then pushes them, one word per cycle, onto a downward-growing stack held in a synchronous single-port memory. A return request (`rti_req`) pops the same words in the opposite order, writes the flags back and hands the popped resume address to the core.

A static select, `full_mode`, picks how much context the hardware saves. With the select low, only the resume address and the flags are stored, and the service routine must save any registers it uses. With the select high, every general register is read through the register-file port and pushed after the flags, one cycle each. On return, the registers are written back through the same port. This gives guaranteed transparency at the price of one extra cycle per register on entry and on return. The select is sampled once, when a sequence starts.

`busy` shows that a sequence is running. Requests that arrive while `busy` is high have no effect. A one-cycle `save_done` or `restore_done` pulse marks the end of a sequence, and `done_pc` carries the address involved.

Top module: `ctx_save_seq`

## Requirements
- R1: When idle, an `irq_take` pulse latches `resume_pc` and `flags_in`. In the next cycle the memory port issues a write of the latched `resume_pc`.
- R2: The second write of an entry sequence stores the latched flags, zero-extended to the word width in bits [FLAG_W-1:0].
- R3: The stack grows downward. A push decrements `sp_out` and writes to the new value. A pop reads at the current `sp_out` and then increments it. Matched entry and return sequences restore `sp_out`, including nested pairs and pairs where the pointer wraps modulo 2^SP_W.
- R4: With the select low, `save_done` is high in the third cycle after the cycle `irq_take` was sampled in (entry cycle counted as the first). `restore_done` is high in the fourth cycle after `rti_req`.
- R5: With the select low, the register-file port is never written, and register contents changed during the service routine stay changed after return.
- R6: With the select high, registers 0 to NREGS-1 are read on `rf_addr` and pushed in ascending order after the flags, one per cycle. `save_done` is then high in cycle 3+NREGS.
- R7: With the select high, the return pops the registers in descending order and writes each one back through `rf_we`/`rf_addr`/`rf_wdata` the cycle after it is read. The flags come next, and the resume address is popped last. `restore_done` is high in cycle 4+NREGS.
- R8: `busy` is high from the cycle after a request is accepted until the sequence finishes. `irq_take` or `rti_req` asserted while `busy` is high starts nothing and changes neither the saved values nor the stack pointer.
- R9: `save_done` is a one-cycle pulse with `done_pc` equal to the latched resume address. `restore_done` is a one-cycle pulse with `done_pc` equal to the popped address and `flags_out` equal to the popped flags. `flags_out` changes only when flags are popped.
- R10: If `irq_take` and `rti_req` are both high in an idle cycle, the entry sequence is started and the return request is dropped.
- R11: `full_mode` is sampled when a sequence is accepted. Changing it mid-sequence changes neither the length nor the content of that sequence.
- R12: While `rst` is high, `busy`, `save_done` and `restore_done` are 0, `sp_out` equals SP_INIT, and `done_pc` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_mode | input | 1 | 1 = save general registers as well, 0 = address and flags only |
| irq_take | input | 1 | Interrupt-accept pulse from the core |
| resume_pc | input | XLEN | Address of the next instruction to run |
| flags_in | input | FLAG_W | Condition flags at interrupt time |
| rti_req | input | 1 | Return-from-interrupt request |
| busy | output | 1 | A save or restore sequence is running |
| save_done | output | 1 | One-cycle pulse at the end of an entry sequence |
| restore_done | output | 1 | One-cycle pulse at the end of a return sequence |
| done_pc | output | XLEN | Saved or restored resume address |
| flags_out | output | FLAG_W | Restored condition flags |
| sp_out | output | SP_W | Current stack pointer |
| rf_addr | output | RIDX_W | Register-file index for read (save) or write (restore) |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | XLEN | Register-file write data |
| rf_rdata | input | XLEN | Register-file read data, combinational on `rf_addr` |
| mem_en | output | 1 | Stack memory access enable |
| mem_we | output | 1 | Stack memory write enable |
| mem_addr | output | SP_W | Stack memory address |
| mem_wdata | output | XLEN | Stack memory write data |
| mem_rdata | input | XLEN | Stack memory read data, valid one cycle after a read |

## Verification
The bench builds the sequencer with four general registers, a five-bit stack pointer and a starting pointer of 3. A single full-mode entry of six words therefore takes the pointer below zero and wraps it to 29. Nested entries also cross that boundary, so the modulo arithmetic on both push and pop is checked. The small register count keeps each full-mode sequence short, while still having more than one register on both sides of the reversal.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PUSH  = 2'd1,
        SQ_POP   = 2'd2,
        SQ_DRAIN = 2'd3
    } sq_state_e;

    // What a stack slot holds; slot position 0 is the resume address,
    // 1 the flags, 2.. the general registers in ascending order
    typedef enum logic [1:0] {
        SL_PC    = 2'd0,
        SL_FLAGS = 2'd1,
        SL_GPR   = 2'd2
    } slot_e;

    // A read issued last cycle whose data is arriving now
    typedef struct packed {
        logic  vld;
        slot_e kind;
    } pend_t;

    localparam int FIXED_SLOTS = 2;

    function automatic int slot_total(input logic full, input int nregs);
        return full ? nregs + FIXED_SLOTS : FIXED_SLOTS;
    endfunction

    function automatic slot_e slot_of(input int pos);
        if (pos == 0)      return SL_PC;
        else if (pos == 1) return SL_FLAGS;
        else               return SL_GPR;
    endfunction

endpackage

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_seq_pkg::*;
#(
    parameter int NREGS = 8,
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             full_mode,
    input  logic             irq_take,
    input  logic             rti_req,
    output sq_state_e        state,
    output logic [POS_W-1:0] pos,
    output logic             mode,
    output logic             push_en,
    output logic             pop_en,
    output logic             accept_irq,
    output logic             save_last,
    output logic             busy
);

    logic [POS_W-1:0] start_last;
    logic [POS_W-1:0] cur_last;
    logic             accept_rti;

    always_comb begin
        start_last = POS_W'(slot_total(full_mode, NREGS) - 1);
        cur_last   = POS_W'(slot_total(mode, NREGS) - 1);
        busy       = (state != SQ_IDLE);
        push_en    = (state == SQ_PUSH);
        pop_en     = (state == SQ_POP);
        accept_irq = (state == SQ_IDLE) && irq_take;
        accept_rti = (state == SQ_IDLE) && !irq_take && rti_req;
        save_last  = push_en && (pos == cur_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            pos   <= '0;
            mode  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (accept_irq) begin
                        state <= SQ_PUSH;
                        pos   <= '0;
                        mode  <= full_mode;
                    end else if (accept_rti) begin
                        state <= SQ_POP;
                        pos   <= start_last;
                        mode  <= full_mode;
                    end
                end
                SQ_PUSH: begin
                    if (pos == cur_last) state <= SQ_IDLE;
                    else                 pos   <= pos + 1'b1;
                end
                SQ_POP: begin
                    if (pos == '0) state <= SQ_DRAIN;
                    else           pos   <= pos - 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(mode)); // R11

    AST_PUSH_RUNS_ON: assert property (@(posedge clk) disable iff (rst)
        (push_en && !save_last) |=> push_en); // R8

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pos <= cur_last)); // R6

endmodule

// File: rtl/ctx_stack_ptr.sv
module ctx_stack_ptr #(
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] addr
);

    // Push: pre-decrement then write; pop: read then post-increment
    always_comb addr = push ? sp - 1'b1 : sp;

    always_ff @(posedge clk) begin
        if (rst)       sp <= SP_INIT;
        else if (push) sp <= sp - 1'b1;
        else if (pop)  sp <= sp + 1'b1;
    end

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R3

endmodule

// File: rtl/ctx_pop_sink.sv
module ctx_pop_sink
    import ctx_seq_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int FLAG_W = 4,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_en,
    input  slot_e             pop_kind,
    input  logic [RIDX_W-1:0] pop_ridx,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              save_last,
    input  logic [XLEN-1:0]   save_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [FLAG_W-1:0] flags_out,
    output logic [XLEN-1:0]   done_pc,
    output logic              save_done,
    output logic              restore_done
);

    pend_t             pend;
    logic [RIDX_W-1:0] pend_ridx;
    logic              pend_pc;
    logic              pend_flags;

    always_comb begin
        pend_pc    = pend.vld && (pend.kind == SL_PC);
        pend_flags = pend.vld && (pend.kind == SL_FLAGS);
        rf_we      = pend.vld && (pend.kind == SL_GPR);
        rf_waddr   = pend_ridx;
        rf_wdata   = mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend         <= '{vld: 1'b0, kind: SL_PC};
            pend_ridx    <= '0;
            flags_out    <= '0;
            done_pc      <= '0;
            save_done    <= 1'b0;
            restore_done <= 1'b0;
        end else begin
            pend         <= '{vld: pop_en, kind: pop_kind};
            pend_ridx    <= pop_ridx;
            save_done    <= save_last;
            restore_done <= pend_pc;
            if (pend_flags) flags_out <= mem_rdata[FLAG_W-1:0];
            if (save_last)    done_pc <= save_pc;
            else if (pend_pc) done_pc <= mem_rdata;
        end
    end

    AST_FLAGS_STILL: assert property (@(posedge clk) disable iff (rst)
        !pend_flags |=> $stable(flags_out)); // R9

    AST_DONE_APART: assert property (@(posedge clk) disable iff (rst)
        !(save_done && restore_done)); // R9

endmodule

// File: rtl/ctx_save_seq.sv
module ctx_save_seq
    import ctx_seq_pkg::*;
#(
    parameter int              XLEN    = 16,
    parameter int              FLAG_W  = 4,
    parameter int              NREGS   = 8,
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1,
    localparam int             RIDX_W  = (NREGS > 1) ? $clog2(NREGS) : 1,
    localparam int             POS_W   = $clog2(NREGS + FIXED_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              full_mode,
    input  logic              irq_take,
    input  logic [XLEN-1:0]   resume_pc,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              rti_req,
    output logic              busy,
    output logic              save_done,
    output logic              restore_done,
    output logic [XLEN-1:0]   done_pc,
    output logic [FLAG_W-1:0] flags_out,
    output logic [SP_W-1:0]   sp_out,
    output logic [RIDX_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [XLEN-1:0]   rf_wdata,
    input  logic [XLEN-1:0]   rf_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [SP_W-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata
);

    sq_state_e         state;
    logic [POS_W-1:0]  pos;
    logic              mode;
    logic              push_en;
    logic              pop_en;
    logic              accept_irq;
    logic              save_last;
    logic [XLEN-1:0]   cap_pc;
    logic [FLAG_W-1:0] cap_flags;
    slot_e             cur_kind;
    logic [RIDX_W-1:0] cur_ridx;
    logic [RIDX_W-1:0] sink_waddr;

    ctx_seq_fsm #(.NREGS(NREGS), .POS_W(POS_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .full_mode  (full_mode),
        .irq_take   (irq_take),
        .rti_req    (rti_req),
        .state      (state),
        .pos        (pos),
        .mode       (mode),
        .push_en    (push_en),
        .pop_en     (pop_en),
        .accept_irq (accept_irq),
        .save_last  (save_last),
        .busy       (busy)
    );

    ctx_stack_ptr #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_sp (
        .clk  (clk),
        .rst  (rst),
        .push (push_en),
        .pop  (pop_en),
        .sp   (sp_out),
        .addr (mem_addr)
    );

    ctx_pop_sink #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RIDX_W(RIDX_W)) u_sink (
        .clk          (clk),
        .rst          (rst),
        .pop_en       (pop_en),
        .pop_kind     (cur_kind),
        .pop_ridx     (cur_ridx),
        .mem_rdata    (mem_rdata),
        .save_last    (save_last),
        .save_pc      (cap_pc),
        .rf_we        (rf_we),
        .rf_waddr     (sink_waddr),
        .rf_wdata     (rf_wdata),
        .flags_out    (flags_out),
        .done_pc      (done_pc),
        .save_done    (save_done),
        .restore_done (restore_done)
    );

    // Context latched at the accept edge
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pc    <= '0;
            cap_flags <= '0;
        end else if (accept_irq) begin
            cap_pc    <= resume_pc;
            cap_flags <= flags_in;
        end
    end

    always_comb begin
        cur_kind = slot_of(int'(pos));
        cur_ridx = RIDX_W'(int'(pos) - FIXED_SLOTS);
        mem_en   = push_en || pop_en;
        mem_we   = push_en;
        rf_addr  = rf_we ? sink_waddr : cur_ridx;
        case (cur_kind)
            SL_PC:    mem_wdata = cap_pc;
            SL_FLAGS: mem_wdata = XLEN'(cap_flags);
            default:  mem_wdata = rf_rdata;
        endcase
    end

    AST_ENTRY_PC_FIRST: assert property (@(posedge clk) disable iff (rst)
        accept_irq |=> (mem_we && (mem_wdata == $past(resume_pc)))); // R1

    AST_FLAGS_SECOND: assert property (@(posedge clk) disable iff (rst)
        (push_en && (pos == POS_W'(1))) |-> (mem_wdata == XLEN'($past(flags_in, 2)))); // R2

    AST_MIN_NO_RF_WRITE: assert property (@(posedge clk) disable iff (rst)
        (busy && !mode) |-> !rf_we); // R5

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (save_done || restore_done) |-> !busy); // R9

endmodule

// File: tb/tb_ctx_save_seq.sv
module tb_ctx_save_seq;

    localparam int              XLEN    = 16;
    localparam int              FLAG_W  = 4;
    localparam int              NREGS   = 4;
    localparam int              SP_W    = 5;
    localparam logic [SP_W-1:0] SP_INIT = 5'd3;
    localparam int              DEPTH   = 1 << SP_W;
    localparam int              RIDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              full_mode = 1'b0;
    logic              irq_take = 1'b0;
    logic [XLEN-1:0]   resume_pc = '0;
    logic [FLAG_W-1:0] flags_in = '0;
    logic              rti_req = 1'b0;
    logic              busy, save_done, restore_done;
    logic [XLEN-1:0]   done_pc;
    logic [FLAG_W-1:0] flags_out;
    logic [SP_W-1:0]   sp_out;
    logic [RIDX_W-1:0] rf_addr;
    logic              rf_we;
    logic [XLEN-1:0]   rf_wdata, rf_rdata;
    logic              mem_en, mem_we;
    logic [SP_W-1:0]   mem_addr;
    logic [XLEN-1:0]   mem_wdata;
    logic [XLEN-1:0]   mem_rdata;

    // Software-side register writes (service routine activity)
    logic              sw_we = 1'b0;
    logic [RIDX_W-1:0] sw_addr = '0;
    logic [XLEN-1:0]   sw_data = '0;

    logic [XLEN-1:0] rf_b  [NREGS];
    logic [XLEN-1:0] mem_b [DEPTH];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctx_save_seq #(.XLEN(XLEN), .FLAG_W(FLAG_W), .NREGS(NREGS),
                   .SP_W(SP_W), .SP_INIT(SP_INIT)) dut (
        .clk(clk), .rst(rst), .full_mode(full_mode), .irq_take(irq_take),
        .resume_pc(resume_pc), .flags_in(flags_in), .rti_req(rti_req),
        .busy(busy), .save_done(save_done), .restore_done(restore_done),
        .done_pc(done_pc), .flags_out(flags_out), .sp_out(sp_out),
        .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign rf_rdata = rf_b[rf_addr];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem_b[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem_b[mem_addr];
        end
    end

    always @(posedge clk) begin
        if (rf_we)      rf_b[rf_addr] <= rf_wdata;
        else if (sw_we) rf_b[sw_addr] <= sw_data;
    end

    // ---------------- behavioural reference model ----------------
    int              m_ph;   // 0 idle, 1 saving, 2 popping, 3 last data in flight
    int              m_pos, m_sp;
    bit              m_mode, m_pv, m_sd, m_rd;
    int              m_ppos;
    logic [XLEN-1:0] m_pdata, m_cpc, m_dpc;
    logic [FLAG_W-1:0] m_cfl, m_flags;
    logic [XLEN-1:0] mref [DEPTH];
    logic [XLEN-1:0] rf_m [NREGS];

    function automatic int tot(input bit md);
        return md ? NREGS + 2 : 2;
    endfunction

    function automatic logic [XLEN-1:0] exp_wd();
        if (m_pos == 0)      return m_cpc;
        else if (m_pos == 1) return XLEN'(m_cfl);
        else                 return rf_m[m_pos-2];
    endfunction

    task automatic model_step();
        bit              npv, nsd, nrd;
        int              nppos;
        logic [XLEN-1:0] npd;
        if (rst) begin
            m_ph = 0; m_pos = 0; m_sp = int'(SP_INIT); m_mode = 0; m_pv = 0;
            m_ppos = 0; m_pdata = '0; m_cpc = '0; m_cfl = '0; m_dpc = '0;
            m_flags = '0; m_sd = 0; m_rd = 0;
            if (sw_we) rf_m[sw_addr] = sw_data;
            return;
        end
        nsd = 0; nrd = 0;
        npv = (m_ph == 2); nppos = m_pos; npd = mref[m_sp];
        if (m_pv && m_ppos >= 2) rf_m[m_ppos-2] = m_pdata;
        else if (sw_we)          rf_m[sw_addr] = sw_data;
        if (m_pv && m_ppos == 1) m_flags = m_pdata[FLAG_W-1:0];
        if (m_pv && m_ppos == 0) begin m_dpc = m_pdata; nrd = 1; end
        case (m_ph)
            0: begin
                if (irq_take) begin
                    m_cpc = resume_pc; m_cfl = flags_in; m_mode = full_mode;
                    m_pos = 0; m_ph = 1;
                end else if (rti_req) begin
                    m_mode = full_mode; m_pos = tot(full_mode) - 1; m_ph = 2;
                end
            end
            1: begin
                mref[(m_sp - 1) & (DEPTH - 1)] = exp_wd();
                m_sp = (m_sp - 1) & (DEPTH - 1);
                if (m_pos == tot(m_mode) - 1) begin
                    m_ph = 0; nsd = 1; m_dpc = m_cpc;
                end else m_pos++;
            end
            2: begin
                m_sp = (m_sp + 1) & (DEPTH - 1);
                if (m_pos == 0) m_ph = 3; else m_pos--;
            end
            default: m_ph = 0;
        endcase
        m_pv = npv; m_ppos = nppos; m_pdata = npd; m_sd = nsd; m_rd = nrd;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(busy === (m_ph != 0), "R8", "busy", 32'(busy), 32'(m_ph != 0));
        check(sp_out === SP_W'(m_sp), "R3", "sp_out", 32'(sp_out), 32'(m_sp));
        check(save_done === m_sd, "R9", "save_done", 32'(save_done), 32'(m_sd));
        check(restore_done === m_rd, "R9", "restore_done", 32'(restore_done), 32'(m_rd));
        check(done_pc === m_dpc, "R9", "done_pc", 32'(done_pc), 32'(m_dpc));
        check(flags_out === m_flags, "R9", "flags_out", 32'(flags_out), 32'(m_flags));
        check(mem_en === (m_ph == 1 || m_ph == 2), "R3", "mem_en", 32'(mem_en), 32'(m_ph == 1 || m_ph == 2));
        if (m_ph == 1) begin
            check(mem_we === 1'b1, "R3", "mem_we on push", 32'(mem_we), 1);
            check(mem_addr === SP_W'(m_sp - 1), "R3", "push address", 32'(mem_addr), 32'((m_sp - 1) & (DEPTH - 1)));
            if (m_pos == 0)
                check(mem_wdata === exp_wd(), "R1", "pushed pc", 32'(mem_wdata), 32'(exp_wd()));
            else if (m_pos == 1)
                check(mem_wdata === exp_wd(), "R2", "pushed flags", 32'(mem_wdata), 32'(exp_wd()));
            else begin
                check(mem_wdata === exp_wd(), "R6", "pushed register", 32'(mem_wdata), 32'(exp_wd()));
                check(rf_addr === RIDX_W'(m_pos - 2), "R6", "read index", 32'(rf_addr), 32'(m_pos - 2));
            end
        end
        if (m_ph == 2) begin
            check(mem_we === 1'b0, "R3", "mem_we on pop", 32'(mem_we), 0);
            check(mem_addr === SP_W'(m_sp), "R3", "pop address", 32'(mem_addr), 32'(m_sp));
        end
        check(rf_we === (m_pv && m_ppos >= 2), "R7", "rf_we", 32'(rf_we), 32'(m_pv && m_ppos >= 2));
        if (m_pv && m_ppos >= 2) begin
            check(rf_addr === RIDX_W'(m_ppos - 2), "R7", "write index", 32'(rf_addr), 32'(m_ppos - 2));
            check(rf_wdata === m_pdata, "R7", "write data", 32'(rf_wdata), 32'(m_pdata));
        end
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare();
    endtask

    // Pulse a request, return the cycle count until the chosen done pulse
    task automatic run_seq(input bit entry, output int n);
        if (entry) irq_take = 1'b1; else rti_req = 1'b1;
        tick();
        n = 1;
        irq_take = 1'b0; rti_req = 1'b0;
        while (!(entry ? save_done : restore_done) && n < 100) begin
            tick();
            n++;
        end
    endtask

    task automatic sw_write(input int idx, input logic [XLEN-1:0] v);
        sw_we = 1'b1; sw_addr = RIDX_W'(idx); sw_data = v;
        tick();
        sw_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [XLEN-1:0] orig [NREGS];
        @(negedge clk);
        // Reset, loading the register file through the software path
        for (int i = 0; i < NREGS; i++) begin
            orig[i] = XLEN'(16'h1000 + i * 16'h0111);
            sw_we = 1'b1; sw_addr = RIDX_W'(i); sw_data = orig[i];
            tick();
        end
        sw_we = 1'b0;
        tick();
        // R12 reset state
        check(busy === 1'b0, "R12", "busy in reset", 32'(busy), 0);
        check(sp_out === SP_INIT, "R12", "sp in reset", 32'(sp_out), 32'(SP_INIT));
        check(save_done === 1'b0 && restore_done === 1'b0, "R12", "done in reset",
              32'({save_done, restore_done}), 0);
        check(done_pc === '0 && flags_out === '0, "R12", "pc/flags in reset",
              32'(done_pc), 0);
        rst = 1'b0;
        tick();

        // Minimal mode round trip
        full_mode = 1'b0; resume_pc = 16'h1234; flags_in = 4'hA;
        run_seq(1'b1, n);
        check(n == 3, "R4", "minimal save latency", 32'(n), 3);
        check(done_pc === 16'h1234, "R9", "save_done pc", 32'(done_pc), 32'h1234);
        check(sp_out === SP_W'(1), "R3", "sp after minimal save", 32'(sp_out), 1);
        sw_write(1, 16'hDEAD);
        run_seq(1'b0, n);
        check(n == 4, "R4", "minimal restore latency", 32'(n), 4);
        check(done_pc === 16'h1234, "R9", "restored pc", 32'(done_pc), 32'h1234);
        check(flags_out === 4'hA, "R2", "restored flags", 32'(flags_out), 32'hA);
        tick();
        check(rf_b[1] === 16'hDEAD, "R5", "register left to software", 32'(rf_b[1]), 32'hDEAD);
        sw_write(1, orig[1]);

        // Full mode round trip with pointer wrap
        full_mode = 1'b1; resume_pc = 16'hBEEF; flags_in = 4'h5;
        run_seq(1'b1, n);
        check(n == 3 + NREGS, "R6", "full save latency", 32'(n), 32'(3 + NREGS));
        check(sp_out === SP_W'(29), "R3", "sp wrapped after full save", 32'(sp_out), 29);
        for (int i = 0; i < NREGS; i++) sw_write(i, XLEN'(16'hC0D0 + i));
        run_seq(1'b0, n);
        check(n == 4 + NREGS, "R7", "full restore latency", 32'(n), 32'(4 + NREGS));
        check(done_pc === 16'hBEEF && flags_out === 4'h5, "R7", "pc/flags after full restore",
              32'(done_pc), 32'hBEEF);
        check(sp_out === SP_INIT, "R3", "sp back after wrap", 32'(sp_out), 32'(SP_INIT));
        tick();
        for (int i = 0; i < NREGS; i++)
            check(rf_b[i] === orig[i], "R7", "register restored", 32'(rf_b[i]), 32'(orig[i]));

        // Requests while busy are ignored
        resume_pc = 16'h4444; flags_in = 4'h6;
        irq_take = 1'b1;
        tick();
        resume_pc = 16'h9999; rti_req = 1'b1;
        tick(); tick(); tick();
        irq_take = 1'b0; rti_req = 1'b0;
        n = 4;
        while (!save_done && n < 100) begin tick(); n++; end
        check(done_pc === 16'h4444, "R8", "pc unaffected by busy requests", 32'(done_pc), 32'h4444);
        check(sp_out === SP_W'(29), "R8", "sp unaffected by busy requests", 32'(sp_out), 29);
        tick();
        check(busy === 1'b0, "R8", "no sequence started by held-off request", 32'(busy), 0);
        run_seq(1'b0, n);
        check(done_pc === 16'h4444 && flags_out === 4'h6, "R9", "restored after busy test",
              32'(done_pc), 32'h4444);

        // Simultaneous requests when idle
        full_mode = 1'b0; resume_pc = 16'h5A5A; flags_in = 4'h3;
        irq_take = 1'b1; rti_req = 1'b1;
        tick();
        irq_take = 1'b0; rti_req = 1'b0;
        check(mem_we === 1'b1 && mem_wdata === 16'h5A5A, "R10", "entry wins over return",
              32'(mem_wdata), 32'h5A5A);
        n = 1;
        while (!save_done && n < 100) begin tick(); n++; end
        check(n == 3 && done_pc === 16'h5A5A, "R10", "entry completed", 32'(n), 3);
        run_seq(1'b0, n);
        check(done_pc === 16'h5A5A && flags_out === 4'h3, "R10", "return after tie",
              32'(done_pc), 32'h5A5A);

        // Mode changed mid-sequence
        full_mode = 1'b1; resume_pc = 16'h7777; flags_in = 4'h9;
        irq_take = 1'b1;
        tick();
        irq_take = 1'b0; full_mode = 1'b0;
        n = 1;
        while (!save_done && n < 100) begin tick(); n++; end
        check(n == 3 + NREGS, "R11", "mode latched on entry", 32'(n), 32'(3 + NREGS));
        full_mode = 1'b1;
        rti_req = 1'b1;
        tick();
        rti_req = 1'b0; full_mode = 1'b0;
        n = 1;
        while (!restore_done && n < 100) begin tick(); n++; end
        check(n == 4 + NREGS, "R11", "mode latched on return", 32'(n), 32'(4 + NREGS));
        check(done_pc === 16'h7777 && flags_out === 4'h9, "R11", "pc/flags after mode change",
              32'(done_pc), 32'h7777);

        // Nested entries, unwound in reverse
        full_mode = 1'b0; resume_pc = 16'h0101; flags_in = 4'h1;
        run_seq(1'b1, n);
        full_mode = 1'b1; resume_pc = 16'h0202; flags_in = 4'h2;
        run_seq(1'b1, n);
        check(sp_out === SP_W'(27), "R3", "sp after nested saves", 32'(sp_out), 27);
        run_seq(1'b0, n);
        check(done_pc === 16'h0202 && flags_out === 4'h2, "R3", "inner context first",
              32'(done_pc), 32'h0202);
        full_mode = 1'b0;
        run_seq(1'b0, n);
        check(done_pc === 16'h0101 && flags_out === 4'h1, "R3", "outer context last",
              32'(done_pc), 32'h0101);
        check(sp_out === SP_INIT, "R3", "sp after nested unwind", 32'(sp_out), 32'(SP_INIT));
        tick(); tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule